// File: doc/BRIEF.md
# Command Slot Status Tracker

This register block serves one serial storage port. It maps a 4 KB local RAM window that holds the command slots, and it tracks which slots hold a command that is still pending. A host writes a command into a slot. The write that lands on the slot's activation register marks that slot active. When the command engine reports that a slot has finished, the block clears the active flag and latches a completion flag for that slot.

The host reads a single status word. Bit 31 is an attention flag. Bits 30:0 are the active flags. A read of the status word can clear all pending completion flags as a side effect, and a control bit turns that side effect off. The top 128 bytes of the window are not a slot. They hold sixteen 8-byte device entries, each made of a status word followed by a QActive word. A second alias range gives the host direct access to each slot's activation register.

Top module: `slot_status_tracker`

## Requirements
- R1: After reset, the status word (0x1800), the completion word (0x1804) and the interrupt status word (0x1808) all read as zero.
- R2: A write to either 32-bit half of the activation register of slot n sets bit n of the status word. The activation register is at byte 0x40 + 0x80·n, and n ranges over 0..30. The written data is stored and reads back at the same address.
- R3: A write to the alias word at 0x1C00 + 8·n + 4·h sets bit n of the status word, for slot n in 0..30 and half h in 0..1. The data appears at window address 0x40 + 0x80·n + 4·h.
- R4: A completion strobe with 5-bit slot index n clears bit n of the status word. From the next cycle on, it also sets bit n of the completion word (0x1804).
- R5: If a slot is activated and completed in the same cycle, its active bit remains set and its completion bit is set.
- R6: Control word (0x1810) bit 3 selects whether a status read clears completions. When bit 3 is 0, an accepted read of the status word clears every completion bit, once, in that cycle. A completion that arrives in the same cycle still ends up set. Writing 1 to bit 0 of the interrupt status word also clears every completion bit.
- R7: While control bit 3 is 1, reading the status word leaves the completion word unchanged.
- R8: Interrupt status bit 0 reads as the OR of all completion bits. Bits k≥1 latch the level on irq_in[k-1] and clear when 1 is written to them. Both the attention output and status bit 31 equal the OR of (interrupt status AND mask word 0x180C).
- R9: Writes to the status word have no effect. An alias write for slot index 31 (0x1CF8, 0x1CFC) sets no active flag and stores nothing.
- R10: Device d, for d in 0..15, has a status word at 0xF80 + 8·d and a QActive word at 0xF84 + 8·d. Both are readable and writable storage. Writes to them set no active flag.
- R11: The read data for a read request is valid, with host_rvalid high, in the cycle after the request. host_rvalid is low in the cycles after non-read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Byte address, 32-bit aligned |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| cpl_valid | input | 1 | Completion strobe from the command engine |
| cpl_slot | input | 5 | Slot index of the completion |
| irq_in | input | INT_W-1 | Interrupt cause levels |
| attention | output | 1 | Masked interrupt summary |

## Verification
Several properties are checked on every cycle: the set and clear of active flags after activation and completion, the precedence of activation over completion, the emptying of completion flags after a clearing read together with the survival of a coincident completion, the one-cycle read latency, the match between status bit 31 and the attention output, and the fact that the decoder never produces an activation for index 31. Other behaviour only the bench scenarios can show. These include the address map itself (slot spacing, the alias mapping, the device entry layout), storage and readback through the RAM, the effect of the no-clear control bit across repeated reads, and the ignored writes to the status word and to alias slot 31.

// File: rtl/slot_trk_pkg.sv
package slot_trk_pkg;
    localparam int ADDR_W   = 13;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 5;
    localparam int NCOR_BIT = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RAM,
        SEL_STATUS,
        SEL_DONE,
        SEL_INTST,
        SEL_INTMSK,
        SEL_CTRL
    } reg_sel_e;
endpackage

// File: rtl/slot_addr_dec.sv
module slot_addr_dec
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 31,
    parameter int RAM_AW    = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [RAM_AW-1:0] ram_widx,
    output logic              act_hit,
    output logic [IDX_W-1:0]  act_slot
);
    localparam logic [4:0] ALIAS_TOP = 5'b11100;
    localparam logic [7:0] REG_TOP   = 8'b1100_0000;

    always_comb begin
        sel      = SEL_NONE;
        ram_widx = '0;
        act_hit  = 1'b0;
        act_slot = '0;
        if (addr[1:0] == 2'b00) begin
            if (!addr[12]) begin
                sel      = SEL_RAM;
                ram_widx = addr[11:2];
                act_slot = addr[11:7];
                act_hit  = (addr[11:7] < IDX_W'(NUM_SLOTS)) && (addr[6:3] == 4'b1000);
            end else if (addr[12:8] == ALIAS_TOP) begin
                if (addr[7:3] < IDX_W'(NUM_SLOTS)) begin
                    sel      = SEL_RAM;
                    ram_widx = {addr[7:3], 4'b1000, addr[2]};
                    act_hit  = 1'b1;
                    act_slot = addr[7:3];
                end
            end else if (addr[12:5] == REG_TOP) begin
                case (addr[4:2])
                    3'd0:    sel = SEL_STATUS;
                    3'd1:    sel = SEL_DONE;
                    3'd2:    sel = SEL_INTST;
                    3'd3:    sel = SEL_INTMSK;
                    3'd4:    sel = SEL_CTRL;
                    default: sel = SEL_NONE;
                endcase
            end
        end
    end

    // R9
    always_comb begin
        act_idx_range_chk: assert (!act_hit || act_slot < IDX_W'(NUM_SLOTS));
    end
endmodule

// File: rtl/slot_lram.sv
module slot_lram #(
    parameter int WORDS  = 1024,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
        rdata <= mem_q[widx];
    end
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_valid,
    input  logic [IDX_W-1:0]     act_slot,
    input  logic                 cpl_valid,
    input  logic [IDX_W-1:0]     cpl_slot,
    input  logic                 clr_done,
    output logic [NUM_SLOTS-1:0] active,
    output logic [NUM_SLOTS-1:0] done
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] active;
        logic [NUM_SLOTS-1:0] done;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            st_d.active[s] = (st_q.active[s] & ~(cpl_valid && cpl_slot == IDX_W'(s)))
                           | (act_valid && act_slot == IDX_W'(s));
            st_d.done[s]   = (st_q.done[s] & ~clr_done)
                           | (cpl_valid && cpl_slot == IDX_W'(s));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign done   = st_q.done;

    // R2
    act_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |=> active[$past(act_slot)]);

    // R4
    cpl_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_slot < IDX_W'(NUM_SLOTS) && !(act_valid && act_slot == cpl_slot))
        |=> (!active[$past(cpl_slot)] && done[$past(cpl_slot)]));

    // R5
    act_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && cpl_valid && act_slot == cpl_slot)
        |=> (active[$past(act_slot)] && done[$past(act_slot)]));

    // R6
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !cpl_valid) |=> (done == '0));

    // R6
    clr_keeps_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && cpl_valid && cpl_slot < IDX_W'(NUM_SLOTS))
        |=> ($countones(done) == 1 && done[$past(cpl_slot)]));
endmodule

// File: rtl/slot_status_tracker.sv
module slot_status_tracker
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 31,
    parameter int INT_W     = 4,
    parameter int RAM_WORDS = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_valid,
    input  logic                    host_write,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic                    host_rvalid,
    output logic [DATA_W-1:0]       host_rdata,
    input  logic                    cpl_valid,
    input  logic [IDX_W-1:0]        cpl_slot,
    input  logic [INT_W-2:0]        irq_in,
    output logic                    attention
);
    localparam int RAM_AW = $clog2(RAM_WORDS);

    typedef struct packed {
        logic [INT_W-1:1]  int_stat;
        logic [INT_W-1:0]  mask;
        logic [DATA_W-1:0] ctrl;
        logic              rvalid;
        logic              rd_ram;
        logic              rd_stat;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    reg_sel_e             sel;
    logic [RAM_AW-1:0]    ram_widx;
    logic                 dec_act;
    logic [IDX_W-1:0]     dec_slot;
    logic [NUM_SLOTS-1:0] active, done;
    logic [DATA_W-1:0]    ram_rdata;
    logic                 rd_req, wr_req, clr_done;
    logic [INT_W-1:0]     int_full;

    slot_addr_dec #(.NUM_SLOTS(NUM_SLOTS), .RAM_AW(RAM_AW)) u_dec (
        .addr     (host_addr),
        .sel      (sel),
        .ram_widx (ram_widx),
        .act_hit  (dec_act),
        .act_slot (dec_slot)
    );

    slot_lram #(.WORDS(RAM_WORDS), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (wr_req && sel == SEL_RAM),
        .widx  (ram_widx),
        .wdata (host_wdata),
        .rdata (ram_rdata)
    );

    slot_tracker #(.NUM_SLOTS(NUM_SLOTS)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_valid (wr_req && dec_act),
        .act_slot  (dec_slot),
        .cpl_valid (cpl_valid),
        .cpl_slot  (cpl_slot),
        .clr_done  (clr_done),
        .active    (active),
        .done      (done)
    );

    assign rd_req    = host_valid && !host_write;
    assign wr_req    = host_valid && host_write;
    assign int_full  = {r_q.int_stat, |done};
    assign attention = |(int_full & r_q.mask);
    assign clr_done  = (rd_req && sel == SEL_STATUS && !r_q.ctrl[NCOR_BIT])
                     || (wr_req && sel == SEL_INTST && host_wdata[0]);

    always_comb begin
        r_d         = r_q;
        r_d.rvalid  = rd_req;
        r_d.rd_ram  = rd_req && sel == SEL_RAM;
        r_d.rd_stat = rd_req && sel == SEL_STATUS;
        if (wr_req && sel == SEL_INTST) begin
            r_d.int_stat = r_q.int_stat & ~host_wdata[INT_W-1:1];
        end
        r_d.int_stat = r_d.int_stat | irq_in;
        if (wr_req && sel == SEL_INTMSK) r_d.mask = host_wdata[INT_W-1:0];
        if (wr_req && sel == SEL_CTRL)   r_d.ctrl = host_wdata;
        r_d.rdata = '0;
        if (rd_req) begin
            case (sel)
                SEL_STATUS: r_d.rdata = {attention, active};
                SEL_DONE:   r_d.rdata = {1'b0, done};
                SEL_INTST:  r_d.rdata = DATA_W'(int_full);
                SEL_INTMSK: r_d.rdata = DATA_W'(r_q.mask);
                SEL_CTRL:   r_d.rdata = r_q.ctrl;
                default:    r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign host_rvalid = r_q.rvalid;
    assign host_rdata  = r_q.rd_ram ? ram_rdata : r_q.rdata;

    // R11
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write) |=> host_rvalid);

    // R11
    no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid && !host_write) |=> !host_rvalid);

    // R8
    attn_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write && sel == SEL_STATUS) |=> (host_rdata[31] == $past(attention)));
endmodule

// File: tb/slot_status_tracker_tb.sv
module slot_status_tracker_tb;
    localparam int INT_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [12:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_rvalid;
    logic [31:0] host_rdata;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_slot = '0;
    logic [INT_W-2:0] irq_in = '0;
    logic        attention;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [30:0]      e_active = '0, e_done = '0;
    logic [INT_W-1:1] e_int = '0;
    logic [INT_W-1:0] e_mask = '0;
    logic [31:0]      e_ctrl = '0;
    logic [31:0]      e_mem [1024];

    always #10 clk = ~clk;

    slot_status_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata), .cpl_valid(cpl_valid), .cpl_slot(cpl_slot),
        .irq_in(irq_in), .attention(attention)
    );

    function automatic logic e_attn();
        return |({e_int, |e_done} & e_mask);
    endfunction

    function automatic logic [31:0] e_status();
        return {e_attn(), e_active};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
        chk({31'd0, host_rvalid}, 32'd1, "R11 rvalid after read");
        d = host_rdata;
    endtask

    task automatic rd_chk(input logic [12:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(a, d);
        chk(d, exp, tag);
        if (a == 13'h1800 && !e_ctrl[3]) e_done = '0;
    endtask

    task automatic cpl(input logic [4:0] s);
        cpl_valid = 1'b1; cpl_slot = s;
        @(negedge clk);
        cpl_valid = 1'b0;
        e_active[s] = 1'b0; e_done[s] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(13'h1800, 32'h0, "R1 status reset");
        rd_chk(13'h1804, 32'h0, "R1 done reset");
        rd_chk(13'h1808, 32'h0, "R1 intstat reset");
        @(negedge clk);
        chk({31'd0, host_rvalid}, 32'd0, "R11 rvalid low when idle");

        // R2 activation sweep through the window, alternating halves
        for (int n = 0; n < 31; n++) begin
            logic [12:0] a;
            a = 13'(32'h40 + n * 128 + (n % 2) * 4);
            wr(a, 32'hA500_0000 | n);
            e_mem[a[11:2]] = 32'hA500_0000 | n;
            e_active[n] = 1'b1;
            rd_chk(13'h1800, e_status(), "R2 active after activation");
        end
        for (int n = 0; n < 31; n++) begin
            logic [12:0] a;
            a = 13'(32'h40 + n * 128 + (n % 2) * 4);
            rd_chk(a, e_mem[a[11:2]], "R2 activation data readback");
        end

        // R4 completion sweep
        for (int n = 30; n >= 0; n--) begin
            cpl(5'(n));
            rd_chk(13'h1804, {1'b0, e_done}, "R4 done bit set");
            if (n % 4 == 0) rd_chk(13'h1800, e_status(), "R4 active cleared");
        end
        rd_chk(13'h1800, e_status(), "R4 all idle");
        rd_chk(13'h1804, 32'h0, "R6 done cleared by status read");

        // R3 alias sweep
        for (int n = 0; n < 31; n++) begin
            logic [12:0] a;
            wr(13'(32'h1C00 + n * 8 + ((n + 1) % 2) * 4), 32'h5A00_0000 | (n << 8));
            a = 13'(32'h40 + n * 128 + ((n + 1) % 2) * 4);
            e_mem[a[11:2]] = 32'h5A00_0000 | (n << 8);
            e_active[n] = 1'b1;
            rd_chk(13'h1800, e_status(), "R3 alias sets active");
            rd_chk(a, e_mem[a[11:2]], "R3 alias data in window");
        end
        for (int n = 0; n < 31; n++) cpl(5'(n));
        rd_chk(13'h1800, e_status(), "R4 cleared after alias sweep");

        // R10 device entries
        for (int dv = 0; dv < 16; dv++) begin
            wr(13'(32'hF80 + dv * 8), 32'hD0D0_0000 | dv);
            wr(13'(32'hF84 + dv * 8), 32'hC0C0_0000 | (dv << 4));
            e_mem[10'(32'h3E0 + dv * 2)] = 32'hD0D0_0000 | dv;
            e_mem[10'(32'h3E1 + dv * 2)] = 32'hC0C0_0000 | (dv << 4);
        end
        for (int dv = 0; dv < 16; dv++) begin
            rd_chk(13'(32'hF80 + dv * 8), e_mem[10'(32'h3E0 + dv * 2)], "R10 device status word");
            rd_chk(13'(32'hF84 + dv * 8), e_mem[10'(32'h3E1 + dv * 2)], "R10 device qactive word");
        end
        rd_chk(13'h1800, e_status(), "R10 device writes set no active bit");

        // R9 ignored writes
        wr(13'h1CF8, 32'hFFFF_FFFF);
        wr(13'h1CFC, 32'hEEEE_EEEE);
        rd_chk(13'h1800, e_status(), "R9 alias slot 31 sets nothing");
        rd_chk(13'hFC0, e_mem[10'h3F0], "R9 alias slot 31 stores nothing");
        rd_chk(13'hFC4, e_mem[10'h3F1], "R9 alias slot 31 stores nothing hi");
        wr(13'h1800, 32'hFFFF_FFFF);
        rd_chk(13'h1800, e_status(), "R9 status write ignored");

        // R5 activation and completion together
        wr(13'h0440, 32'h1);
        e_active[8] = 1'b1;
        host_valid = 1'b1; host_write = 1'b1; host_addr = 13'h0440; host_wdata = 32'h2;
        cpl_valid = 1'b1; cpl_slot = 5'd8;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0; cpl_valid = 1'b0;
        e_done[8] = 1'b1;
        rd_chk(13'h1804, {1'b0, e_done}, "R5 done set on collision");
        rd_chk(13'h1800, e_status(), "R5 active kept on collision");
        cpl(5'd8);

        // R7 no-clear-on-read
        wr(13'h1810, 32'h8);
        e_ctrl = 32'h8;
        rd_chk(13'h1810, 32'h8, "R7 ctrl readback");
        cpl(5'd3); cpl(5'd17);
        rd_chk(13'h1800, e_status(), "R7 status read 1");
        rd_chk(13'h1800, e_status(), "R7 status read 2");
        rd_chk(13'h1804, {1'b0, e_done}, "R7 done preserved");

        // R6 clear on read with coincident completion
        wr(13'h1810, 32'h0);
        e_ctrl = 32'h0;
        wr(13'h0C40, 32'h3);
        e_active[24] = 1'b1;
        host_valid = 1'b1; host_write = 1'b0; host_addr = 13'h1800;
        cpl_valid = 1'b1; cpl_slot = 5'd24;
        @(negedge clk);
        host_valid = 1'b0; cpl_valid = 1'b0;
        chk(host_rdata, e_status(), "R6 status on clearing read");
        e_active[24] = 1'b0;
        e_done = '0; e_done[24] = 1'b1;
        rd_chk(13'h1804, {1'b0, e_done}, "R6 coincident completion kept");
        wr(13'h1808, 32'h1);
        e_done = '0;
        rd_chk(13'h1804, 32'h0, "R6 intstat bit0 write clears done");

        // R8 interrupts and attention
        wr(13'h180C, 32'h5);
        e_mask = 4'h5;
        chk({31'd0, attention}, 32'd0, "R8 attention idle");
        irq_in = 3'b010;
        @(negedge clk);
        irq_in = '0;
        e_int[2] = 1'b1;
        rd_chk(13'h1808, 32'h4, "R8 cause latched");
        chk({31'd0, attention}, {31'd0, e_attn()}, "R8 attention from cause");
        rd_chk(13'h1800, e_status(), "R8 status bit31 set");
        irq_in = 3'b001;
        @(negedge clk);
        irq_in = '0;
        e_int[1] = 1'b1;
        wr(13'h1808, 32'h4);
        e_int[2] = 1'b0;
        rd_chk(13'h1808, 32'h2, "R8 W1C leaves other cause");
        chk({31'd0, attention}, 32'd0, "R8 unmasked cause gives no attention");
        cpl(5'd0);
        chk({31'd0, attention}, 32'd1, "R8 completion raises attention");
        rd_chk(13'h1808, 32'h3, "R8 bit0 follows completions");
        rd_chk(13'h1800, e_status(), "R8 status bit31 with completion");
        chk({31'd0, attention}, 32'd0, "R8 attention drops after clear");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule